// File: doc/BRIEF.md
# Strided Two-Dimensional Register Gather with Width Extension

This engine moves a short run of elements (at most MAX_ELEM, 32 by default) from a two-dimensional strided window of memory into the register file. A start pulse hands it the decoded operand fields. These are the element type, an inner and an outer count, two signed element strides, the resolved base address, and a list of register numbers with one byte per element. The engine then walks the window and reads each element. It widens each element to 32 bits and writes it to the register named for it in the list.

Memory reads are pipelined, so several may be in flight at once. Responses arrive in request order and are parked in a small queue. Register writes leave through a single write port, strictly in element order. A 64-bit element takes two writes, into an even/odd register pair. The caller may change the operand fields after the start pulse, because the engine keeps its own copy. The operand is assumed to be valid already: counts of 1 to 32 with a product of at most 32, a legal type, and even register numbers for 64-bit elements.

Top module: `gather_load`

## Requirements
- R1: After reset, busy, done, memReqValid and rfWe are all low.
- R2: Element k is read from base + (i0*stride0 + i1*stride1) * bytes, where bytes is the element size. The outer loop runs over index i1 and the inner loop over index i0, and requests are issued in that order. memReqSize gives the size as log2 of the byte count (0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B).
- R3: Every request keeps the address bits from bit WIN_W (24) upward equal to those of the base. Offsets wrap within the 16 MB window the base lies in.
- R4: elemType codes 0 (u8) and 2 (u16) are zero-extended to 32 bits. Codes 1 (i8) and 3 (i16) are sign-extended. Response bits above the element width have no effect.
- R5: Codes 4 (u32), 5 (i32) and 6 (fp32) are written as the low 32 response bits, unchanged.
- R6: Code 7 (u64) makes two consecutive writes. The first puts bits 31:0 into the register named in the list. The second puts bits 63:32 into that number with bit 0 set.
- R7: Register writes retire in element order, k = 0, 1, 2 and so on. The register for element k is byte k of regList, at bits 8k+7:8k.
- R8: At most MAX_OUT reads are outstanding, counting from request until the element's last register write. Later reads are issued before earlier elements retire.
- R9: busy is high from the cycle after start until the cycle of the last register write. done is a one-cycle pulse in the following cycle, with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the operand fields below |
| elemType | input | 3 | Element type code (see R4 to R6) |
| cnt0 | input | CNT_W | Inner count, 1 to MAX_ELEM |
| cnt1 | input | CNT_W | Outer count, 1 to MAX_ELEM |
| stride0 | input | STRIDE_W | Signed inner stride, in elements |
| stride1 | input | STRIDE_W | Signed outer stride, in elements |
| baseAddr | input | ADDR_W | Resolved start address |
| regList | input | 8*MAX_ELEM | Destination register number per element, one byte each |
| memReqValid | output | 1 | Read request this cycle |
| memReqAddr | output | ADDR_W | Read address |
| memReqSize | output | 2 | log2 of read size in bytes |
| memRspValid | input | 1 | Read response, in request order |
| memRspData | input | 64 | Response data, element in the low bits |
| rfWe | output | 1 | Register write strobe |
| rfAddr | output | REG_W | Register number |
| rfData | output | 32 | Widened register value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default parameters: 32 elements, four outstanding reads, a 24-bit window and 8-bit register numbers. It sweeps all eight element types over five shapes. The shapes include a single element, full 32-long rows and columns, and mixed negative strides. Memory latency is either one cycle, or five cycles with jitter. The long latency is what fills the four-entry read budget. It also makes the two-write u64 retire overlap with responses still arriving. Two extra transfers start near the upper and lower edges of a 16 MB window, so the offset wraps in both directions.

// File: rtl/gather_load_pkg.sv
package gather_load_pkg;

  localparam int RSP_BITS = 64;
  localparam int REG_BITS = 32;

  typedef enum logic [2:0] {
    ET_U8  = 3'd0,
    ET_I8  = 3'd1,
    ET_U16 = 3'd2,
    ET_I16 = 3'd3,
    ET_U32 = 3'd4,
    ET_I32 = 3'd5,
    ET_F32 = 3'd6,
    ET_U64 = 3'd7
  } elemType_e;

  // Control-to-datapath strobes, all qualified in the same cycle.
  typedef struct packed {
    logic loadCfg;   // capture operand fields
    logic issue;     // one read request leaves this cycle
    logic stepOuter; // the request just issued closes an inner row
    logic write;     // register write port active
    logic writeHi;   // this write carries the upper half of a u64
    logic pop;       // head of response queue retires
  } strobes_t;

  function automatic logic [1:0] sizeLog2(elemType_e t);
    case (t)
      ET_U8, ET_I8:   return 2'd0;
      ET_U16, ET_I16: return 2'd1;
      ET_U64:         return 2'd3;
      default:        return 2'd2;
    endcase
  endfunction

  function automatic logic [REG_BITS-1:0] widenElem(elemType_e t, logic [RSP_BITS-1:0] raw,
                                                    logic hiHalf);
    case (t)
      ET_U8:   return {24'd0, raw[7:0]};
      ET_I8:   return {{24{raw[7]}}, raw[7:0]};
      ET_U16:  return {16'd0, raw[15:0]};
      ET_I16:  return {{16{raw[15]}}, raw[15:0]};
      ET_U64:  return hiHalf ? raw[63:32] : raw[31:0];
      default: return raw[31:0];
    endcase
  endfunction

endpackage

// File: rtl/gather_load_ctrl.sv
module gather_load_ctrl
  import gather_load_pkg::*;
#(
  parameter int MAX_ELEM = 32,
  parameter int MAX_OUT  = 4,
  parameter int CNT_W    = $clog2(MAX_ELEM + 1),
  parameter int IDX_W    = $clog2(MAX_ELEM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  elemType_e        elemType,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  input  logic             fifoEmpty,
  output strobes_t         strobes,
  output logic [IDX_W-1:0] elemIdx,
  output logic             busy,
  output logic             done
);

  localparam int TOT_W = 2 * CNT_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt0Q;
  logic [CNT_W-1:0] innerIdx;
  logic [TOT_W-1:0] total;
  logic [TOT_W-1:0] issued;
  logic [TOT_W-1:0] retired;
  logic [TOT_W-1:0] inflight;
  logic             wideQ;
  logic             hiPhase;
  logic             lastPop;

  assign inflight = issued - retired;

  always_comb begin
    strobes           = '0;
    strobes.loadCfg   = (state == S_IDLE) && start;
    strobes.issue     = (state == S_RUN) && (issued < total) && (inflight < TOT_W'(MAX_OUT));
    strobes.stepOuter = strobes.issue && (innerIdx == cnt0Q - CNT_W'(1));
    strobes.write     = (state == S_RUN) && !fifoEmpty;
    strobes.writeHi   = strobes.write && wideQ && hiPhase;
    strobes.pop       = strobes.write && (!wideQ || hiPhase);
  end

  assign lastPop = strobes.pop && (retired == total - TOT_W'(1));
  assign elemIdx = retired[IDX_W-1:0];
  assign busy    = (state == S_RUN);
  assign done    = (state == S_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt0Q    <= '0;
      innerIdx <= '0;
      total    <= '0;
      issued   <= '0;
      retired  <= '0;
      wideQ    <= 1'b0;
      hiPhase  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (strobes.loadCfg) begin
            cnt0Q    <= cnt0;
            total    <= TOT_W'(cnt0) * TOT_W'(cnt1);
            innerIdx <= '0;
            issued   <= '0;
            retired  <= '0;
            wideQ    <= (elemType == ET_U64);
            hiPhase  <= 1'b0;
            state    <= S_RUN;
          end
        end
        S_RUN: begin
          if (strobes.issue) begin
            issued   <= issued + TOT_W'(1);
            innerIdx <= strobes.stepOuter ? '0 : innerIdx + CNT_W'(1);
          end
          if (strobes.write) hiPhase <= wideQ && !hiPhase;
          if (strobes.pop) retired <= retired + TOT_W'(1);
          if (lastPop) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    inflight <= TOT_W'(MAX_OUT));

  // R6
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeHi |-> ($past(strobes.write) && !$past(strobes.writeHi)));

  // R7
  retire_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && !lastPop) |=> (elemIdx == IDX_W'($past(elemIdx) + IDX_W'(1))));

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(strobes.pop) && !busy));

endmodule

// File: rtl/gather_load_dp.sv
module gather_load_dp
  import gather_load_pkg::*;
#(
  parameter int MAX_ELEM = 32,
  parameter int MAX_OUT  = 4,
  parameter int ADDR_W   = 64,
  parameter int WIN_W    = 24,
  parameter int STRIDE_W = 32,
  parameter int REG_W    = 8,
  parameter int IDX_W    = $clog2(MAX_ELEM)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strobes,
  input  logic [IDX_W-1:0]      elemIdx,
  input  elemType_e             elemType,
  input  logic [STRIDE_W-1:0]   stride0,
  input  logic [STRIDE_W-1:0]   stride1,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [8*MAX_ELEM-1:0] regList,
  input  logic                  memRspValid,
  input  logic [RSP_BITS-1:0]   memRspData,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [1:0]            memReqSize,
  output logic                  fifoEmpty,
  output logic                  rfWe,
  output logic [REG_W-1:0]      rfAddr,
  output logic [REG_BITS-1:0]   rfData
);

  localparam int HI_W  = ADDR_W - WIN_W;
  localparam int PTR_W = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
  localparam int FCT_W = $clog2(MAX_OUT + 1);

  // ---------------- operand capture and address walk ----------------
  elemType_e             typeQ;
  logic [8*MAX_ELEM-1:0] regListQ;
  logic [HI_W-1:0]       winHi;
  logic [WIN_W-1:0]      rowOff;
  logic [WIN_W-1:0]      curOff;
  logic [WIN_W-1:0]      step0;
  logic [WIN_W-1:0]      step1;
  logic [ADDR_W-1:0]     s0Ext;
  logic [ADDR_W-1:0]     s1Ext;
  logic [1:0]            lgIn;

  assign s0Ext = {{(ADDR_W-STRIDE_W){stride0[STRIDE_W-1]}}, stride0};
  assign s1Ext = {{(ADDR_W-STRIDE_W){stride1[STRIDE_W-1]}}, stride1};
  assign lgIn  = sizeLog2(elemType);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ    <= ET_U8;
      regListQ <= '0;
      winHi    <= '0;
      rowOff   <= '0;
      curOff   <= '0;
      step0    <= '0;
      step1    <= '0;
    end else if (strobes.loadCfg) begin
      typeQ    <= elemType;
      regListQ <= regList;
      winHi    <= baseAddr[ADDR_W-1:WIN_W];
      rowOff   <= baseAddr[WIN_W-1:0];
      curOff   <= baseAddr[WIN_W-1:0];
      step0    <= WIN_W'(s0Ext << lgIn);
      step1    <= WIN_W'(s1Ext << lgIn);
    end else if (strobes.issue) begin
      if (strobes.stepOuter) begin
        rowOff <= rowOff + step1;
        curOff <= rowOff + step1;
      end else begin
        curOff <= curOff + step0;
      end
    end
  end

  assign memReqAddr = {winHi, curOff};
  assign memReqSize = sizeLog2(typeQ);

  // ---------------- in-order response queue ----------------
  logic [RSP_BITS-1:0] fifoMem [MAX_OUT];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;
  logic [FCT_W-1:0]    fifoCnt;

  assign fifoEmpty = (fifoCnt == '0);

  always_ff @(posedge clk) begin
    if (memRspValid) fifoMem[wrPtr] <= memRspData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (memRspValid) wrPtr <= (wrPtr == PTR_W'(MAX_OUT - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (strobes.pop) rdPtr <= (rdPtr == PTR_W'(MAX_OUT - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({memRspValid, strobes.pop})
        2'b10:   fifoCnt <= fifoCnt + FCT_W'(1);
        2'b01:   fifoCnt <= fifoCnt - FCT_W'(1);
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  // ---------------- register write port ----------------
  logic [REG_W-1:0] regSel;

  assign regSel = regListQ[{elemIdx, 3'b000} +: REG_W];
  assign rfWe   = strobes.write;
  assign rfAddr = strobes.writeHi ? {regSel[REG_W-1:1], 1'b1} : regSel;
  assign rfData = widenElem(typeQ, fifoMem[rdPtr], strobes.writeHi);

  // R8
  rsp_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> ((fifoCnt < FCT_W'(MAX_OUT)) || strobes.pop));

  // R3
  window_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && $past(strobes.issue)) |->
      (memReqAddr[ADDR_W-1:WIN_W] == $past(memReqAddr[ADDR_W-1:WIN_W])));

  // R4
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && typeQ == ET_I8) |-> (rfData[31:8] == {24{rfData[7]}}));

endmodule

// File: rtl/gather_load.sv
module gather_load
  import gather_load_pkg::*;
#(
  parameter int MAX_ELEM = 32,
  parameter int MAX_OUT  = 4,
  parameter int ADDR_W   = 64,
  parameter int WIN_W    = 24,
  parameter int STRIDE_W = 32,
  parameter int REG_W    = 8,
  parameter int CNT_W    = $clog2(MAX_ELEM + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [2:0]            elemType,
  input  logic [CNT_W-1:0]      cnt0,
  input  logic [CNT_W-1:0]      cnt1,
  input  logic [STRIDE_W-1:0]   stride0,
  input  logic [STRIDE_W-1:0]   stride1,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [8*MAX_ELEM-1:0] regList,
  output logic                  memReqValid,
  output logic [ADDR_W-1:0]     memReqAddr,
  output logic [1:0]            memReqSize,
  input  logic                  memRspValid,
  input  logic [63:0]           memRspData,
  output logic                  rfWe,
  output logic [REG_W-1:0]      rfAddr,
  output logic [31:0]           rfData,
  output logic                  busy,
  output logic                  done
);

  localparam int IDX_W = $clog2(MAX_ELEM);

  strobes_t         strobes;
  logic [IDX_W-1:0] elemIdx;
  logic             fifoEmpty;
  elemType_e        typeIn;

  assign typeIn      = elemType_e'(elemType);
  assign memReqValid = strobes.issue;

  gather_load_ctrl #(
    .MAX_ELEM(MAX_ELEM), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .elemType(typeIn),
    .cnt0(cnt0), .cnt1(cnt1), .fifoEmpty(fifoEmpty),
    .strobes(strobes), .elemIdx(elemIdx), .busy(busy), .done(done)
  );

  gather_load_dp #(
    .MAX_ELEM(MAX_ELEM), .MAX_OUT(MAX_OUT), .ADDR_W(ADDR_W), .WIN_W(WIN_W),
    .STRIDE_W(STRIDE_W), .REG_W(REG_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .elemIdx(elemIdx), .elemType(typeIn),
    .stride0(stride0), .stride1(stride1), .baseAddr(baseAddr), .regList(regList),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .memReqSize(memReqSize), .fifoEmpty(fifoEmpty),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData)
  );

endmodule

// File: tb/gather_load_bench.sv
module gather_load_bench;

  localparam int MAX_OUT = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   elemType = '0;
  logic [5:0]   cnt0 = 6'd1, cnt1 = 6'd1;
  logic [31:0]  stride0 = '0, stride1 = '0;
  logic [63:0]  baseAddr = '0;
  logic [255:0] regList = '0;
  logic         memReqValid;
  logic [63:0]  memReqAddr;
  logic [1:0]   memReqSize;
  logic         memRspValid = 1'b0;
  logic [63:0]  memRspData = '0;
  logic         rfWe;
  logic [7:0]   rfAddr;
  logic [31:0]  rfData;
  logic         busy, done;

  always #5 clk = ~clk;

  gather_load u_gather_load (
    .clk(clk), .rstN(rstN), .start(start), .elemType(elemType), .cnt0(cnt0), .cnt1(cnt1),
    .stride0(stride0), .stride1(stride1), .baseAddr(baseAddr), .regList(regList),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqSize(memReqSize),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData), .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] memWord(input logic [63:0] a);
    logic [31:0] x = a[31:0] ^ a[63:32];
    return {x * 32'h0019660D + 32'h3C6EF35F, (x ^ 32'hA5A55A5A) * 32'h9E3779B1};
  endfunction

  // expected job content
  logic [63:0] expAddr [64];
  logic [7:0]  expReg  [64];
  logic [31:0] expVal  [64];
  bit          expLast [64];
  logic [1:0]  expSize;
  int          expReqs, expWrs, curType;
  string       valTag;

  // monitor state
  logic [63:0] obsAddr [64];
  int          dueArr  [64];
  int cyc = 0, reqSeen = 0, wrSeen = 0, elemDone = 0, rspIdx = 0, lastDue = 0;
  int lastWrCyc = -10, peak = 0, jobLat = 1;
  bit jobJit = 0, jobActive = 0, doneSeen = 0, overBudget = 0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (memReqValid) begin
        if (reqSeen < expReqs) begin
          chk(memReqAddr == expAddr[reqSeen], "R2/R3", "request address", memReqAddr,
              expAddr[reqSeen]);
          chk(memReqSize == expSize, "R2", "request size", 64'(memReqSize), 64'(expSize));
        end else chk(1'b0, "R2", "extra request", 64'(reqSeen), 64'(expReqs));
        if (reqSeen < 64) begin
          obsAddr[reqSeen] = memReqAddr;
          dueArr[reqSeen]  = cyc + jobLat + (jobJit ? (reqSeen % 3) : 0);
          if (dueArr[reqSeen] < lastDue) dueArr[reqSeen] = lastDue;
          lastDue = dueArr[reqSeen];
        end
        reqSeen++;
      end
      if (jobActive) begin
        if (reqSeen - elemDone > peak) peak = reqSeen - elemDone;
        if (reqSeen - elemDone > MAX_OUT) overBudget = 1;
      end
      if (rfWe) begin
        if (wrSeen < expWrs) begin
          chk(rfAddr == expReg[wrSeen], "R7/R6", "write register", 64'(rfAddr),
              64'(expReg[wrSeen]));
          chk(rfData == expVal[wrSeen], valTag, "write data", 64'(rfData),
              64'(expVal[wrSeen]));
          if (expLast[wrSeen]) elemDone++;
        end else chk(1'b0, "R7", "extra write", 64'(wrSeen), 64'(expWrs));
        wrSeen++;
        lastWrCyc = cyc;
      end
      if (done) begin
        chk(lastWrCyc == cyc - 1, "R9", "done one cycle after last write",
            64'(cyc - lastWrCyc), 64'd1);
        chk(!busy, "R9", "busy low with done", 64'(busy), 64'd0);
        doneSeen = 1;
      end
      if (rspIdx < reqSeen && rspIdx < 64 && dueArr[rspIdx] <= cyc) begin
        memRspValid = 1'b1;
        memRspData  = memWord(obsAddr[rspIdx]);
        rspIdx++;
      end else begin
        memRspValid = 1'b0;
        memRspData  = '0;
      end
    end
  end

  bit aborted = 0;

  task automatic runJob(input int t, input int c0, input int c1, input int s0, input int s1,
                        input logic [63:0] base, input int lat, input bit jit, input int seed);
    int nb, w, k;
    logic [63:0] a, raw;
    logic [7:0]  r;
    logic [255:0] rl;
    longint off;
    nb = 1 << ((t == 7) ? 3 : (t >= 4) ? 2 : (t >= 2) ? 1 : 0);
    expSize = (t == 7) ? 2'd3 : (t >= 4) ? 2'd2 : (t >= 2) ? 2'd1 : 2'd0;
    valTag = (t == 7) ? "R6" : (t >= 4) ? "R5" : "R4";
    curType = t;
    rl = '0;
    for (int j = 0; j < 32; j++) begin
      r = 8'((j * 7 + seed) & 31);
      if (t == 7) r[0] = 1'b0;
      rl[j*8 +: 8] = r;
    end
    k = 0; w = 0;
    for (int i1 = 0; i1 < c1; i1++) begin
      for (int i0 = 0; i0 < c0; i0++) begin
        off = (longint'(i0) * longint'(s0) + longint'(i1) * longint'(s1)) * longint'(nb);
        a = base + 64'(off);
        a = {base[63:24], a[23:0]};
        expAddr[k] = a;
        raw = memWord(a);
        r = rl[k*8 +: 8];
        case (t)
          0: expVal[w] = {24'd0, raw[7:0]};
          1: expVal[w] = {{24{raw[7]}}, raw[7:0]};
          2: expVal[w] = {16'd0, raw[15:0]};
          3: expVal[w] = {{16{raw[15]}}, raw[15:0]};
          default: expVal[w] = raw[31:0];
        endcase
        expReg[w] = r;
        if (t == 7) begin
          expLast[w] = 0; w++;
          expReg[w] = {r[7:1], 1'b1}; expVal[w] = raw[63:32];
        end
        expLast[w] = 1; w++;
        k++;
      end
    end
    expReqs = k; expWrs = w;
    reqSeen = 0; wrSeen = 0; elemDone = 0; rspIdx = 0; lastDue = 0; peak = 0;
    overBudget = 0; doneSeen = 0; jobLat = lat; jobJit = jit;
    elemType = 3'(t); cnt0 = 6'(c0); cnt1 = 6'(c1);
    stride0 = 32'(s0); stride1 = 32'(s1); baseAddr = base; regList = rl;
    jobActive = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    regList = ~rl; baseAddr = ~base;   // operands are held internally
    chk(busy, "R9", "busy after start", 64'(busy), 64'd1);
    for (int g = 0; g < 3000 && !doneSeen; g++) @(negedge clk);
    if (!doneSeen) begin
      chk(1'b0, "R9", "watchdog: no done", 64'd0, 64'd1);
      aborted = 1;
    end
    @(negedge clk);
    jobActive = 0;
    chk(reqSeen == expReqs, "R2", "request count", 64'(reqSeen), 64'(expReqs));
    chk(wrSeen == expWrs, "R7", "write count", 64'(wrSeen), 64'(expWrs));
    chk(!overBudget, "R8", "outstanding reads within budget", 64'(peak), 64'(MAX_OUT));
    if (lat >= 4 && expReqs >= MAX_OUT)
      chk(peak == MAX_OUT, "R8", "reads issued ahead to full budget", 64'(peak),
          64'(MAX_OUT));
  endtask

  int cnt0Tab [5] = '{1, 32, 1, 4, 5};
  int cnt1Tab [5] = '{1, 1, 32, 8, 6};
  int s0Tab   [5] = '{1, 1, -3, 2, -1};
  int s1Tab   [5] = '{1, 0, 5, -9, 7};

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReqValid && !rfWe, "R1", "reset outputs quiet",
        {60'd0, busy, done, memReqValid, rfWe}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReqValid && !rfWe, "R1", "idle after reset release",
        {60'd0, busy, done, memReqValid, rfWe}, 64'd0);
    for (int t = 0; t < 8 && !aborted; t++)
      for (int sh = 0; sh < 5 && !aborted; sh++)
        for (int lm = 0; lm < 2 && !aborted; lm++)
          runJob(t, cnt0Tab[sh], cnt1Tab[sh], s0Tab[sh], s1Tab[sh],
                 64'h0000_1234_0080_0000 + 64'(sh * 64), lm ? 5 : 1, lm == 1, t * 5 + sh);
    // R3: window wrap upward and downward
    if (!aborted) runJob(4, 8, 1, 1, 0, 64'hABCD_0000_00FF_FFF0, 2, 0, 3);
    if (!aborted) runJob(7, 4, 1, -1, 0, 64'h0000_0042_0300_0008, 5, 1, 9);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule